// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a small set of general-purpose input pins and remembers, per pin, that the level has changed since the CPU last looked. Each pin passes through a two-flop synchronizer and a filter that accepts a new level only after it has been seen on two consecutive sample ticks. Accepted changes latch a per-pin change flag. A per-pin enable field decides which of those flags also raise one summary bit at the top of an interrupt status register. The lower status bits are level inputs supplied by other interrupt sources.

A mask register gates the status bits onto an active-low interrupt output, while the status itself is always presented unmasked. The CPU side is reduced to write strobes for the enable field and the mask, two read-data outputs (change register and status register) and one read strobe that clears the change flags and the summary bit. A change accepted in the same cycle as that clearing read is kept.

Top module: `pin_change_irq`

## Requirements
- R1: When the filtered level of pin i changes, bit 4+i of `chg_data` becomes 1 and stays 1 until a clearing read.
- R2: A one-cycle pulse on `rd_chg` clears bits 7:4 of `chg_data` and bit 7 of `stat_data` from the following cycle on.
- R3: Bits 3:0 of `chg_data` show the current synchronized level of pins 3..0 (two clock cycles behind `pin_in`), not a latched copy.
- R4: Bit 7 of `stat_data` is set only when a change flag is raised for a pin whose bit in the enable field (written from `wr_data[3:0]` by `wr_en_sel`) is 1; flags raised on disabled pins, and enabling a pin whose flag is already set, leave bit 7 unchanged.
- R5: `irq_n` is 0 exactly when some bit of `stat_data` and the same bit of the mask (written from `wr_data[7:0]` by `wr_mask_sel`) are both 1, otherwise 1.
- R6: `stat_data` returns the unmasked status, bit 7 being the summary bit and bits 6:0 the levels of `other_src[6:0]`, whatever the mask holds.
- R7: After reset the change flags, the summary bit, the enable field and the mask are 0, so with `other_src` at 0 `stat_data` is 0x00 and `irq_n` is 1.
- R8: A level must differ from the accepted level on two consecutive sample ticks (one every `SAMPLE_DIV` cycles) to count; a pulse shorter than `SAMPLE_DIV` cycles sets no flag.
- R9: A change accepted in the same cycle as a clearing read sets its flag (and the summary bit when enabled) again after the clear.
- R10: The first sample tick after reset adopts the pin level present then without raising a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | N_PINS | Asynchronous general-purpose inputs |
| other_src | input | STAT_W-1 | Level inputs for status bits 6:0 |
| wr_data | input | STAT_W | Write data for enable field and mask |
| wr_en_sel | input | 1 | Write strobe for the per-pin enable field |
| wr_mask_sel | input | 1 | Write strobe for the interrupt mask |
| rd_chg | input | 1 | Read strobe of the change register, clears flags and summary bit |
| chg_data | output | 2*N_PINS | Change flags (high half) and live levels (low half) |
| stat_data | output | STAT_W | Unmasked interrupt status |
| irq_n | output | 1 | Active-low masked interrupt |

## Verification
The bench drives a glitch of two cycles, which a filter reacting to a single sample would turn into a spurious flag, and holds a pin high through reset, which a filter without priming would report as a change. It keeps the clearing read asserted every cycle while a pin changes, so a design that lets the clear win would never show the flag at all. It also enables a pin after its flag is already set and changes a disabled pin, where a design deriving the summary bit from flag levels or ignoring the enable would raise bit 7, and it sweeps the mask while the status is active to catch a status read that is masked or an output of the wrong polarity.

// File: rtl/pcx_pkg.sv
// Shared constants and types for the pin-change interrupt controller.
// Assumes: status bit 7 is the summary bit, lower bits are external levels.
package pcx_pkg;
    localparam int PCX_DEF_PINS   = 4;
    localparam int PCX_DEF_STAT_W = 8;
    localparam int PCX_DEF_DIV    = 4;

    // State of one pin filter between ticks
    typedef enum logic [1:0] {
        FLT_UNPRIMED = 2'd0,
        FLT_STABLE   = 2'd1,
        FLT_PENDING  = 2'd2
    } flt_state_t;
endpackage

// File: rtl/pcx_tick_gen.sv
// Sample tick generator: one-cycle pulse every DIV clock cycles.
// Assumes: DIV >= 2.
module pcx_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running modulo-DIV counter
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pcx_pin_filter.sv
// One pin: two-flop synchronizer and two-tick change filter.
// Assumes: pin is asynchronous; tick is a one-cycle pulse. Emits a
// one-cycle evt when a new level has been accepted.
module pcx_pin_filter
    import pcx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic level,
    output logic evt
);
    logic       s1_q, s2_q;
    logic       acc_q;
    flt_state_t st_q;

    // Two-flop synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
        end
    end

    // Filter: prime on first tick, accept a differing level on the second consecutive tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FLT_UNPRIMED;
            acc_q <= 1'b0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (tick) begin
                unique case (st_q)
                    FLT_UNPRIMED: begin
                        acc_q <= s2_q;
                        st_q  <= FLT_STABLE;
                    end
                    FLT_STABLE: begin
                        if (s2_q != acc_q) st_q <= FLT_PENDING;
                    end
                    FLT_PENDING: begin
                        if (s2_q != acc_q) begin
                            acc_q <= s2_q;
                            evt   <= 1'b1;
                        end
                        st_q <= FLT_STABLE;
                    end
                    default: st_q <= FLT_UNPRIMED;
                endcase
            end
        end
    end

    assign level = s2_q;

    a_r8_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(tick));
    a_r10_no_evt_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_UNPRIMED) |=> !evt);
endmodule

// File: rtl/pcx_status.sv
// Change flags, summary bit, enable field, mask and interrupt output.
// Assumes: evt are one-cycle pulses; rd_clr is the change-register read
// strobe. A set event in the same cycle as rd_clr wins over the clear.
module pcx_status #(
    parameter int N_PINS = 4,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] evt,
    input  logic [STAT_W-2:0] other_src,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              wr_en_sel,
    input  logic              wr_mask_sel,
    input  logic              rd_clr,
    output logic [N_PINS-1:0] flags,
    output logic [STAT_W-1:0] stat,
    output logic              irq_n
);
    logic [N_PINS-1:0] en_q;
    logic [STAT_W-1:0] mask_q;
    logic              sum_q;

    // Per-pin change flags: clear on read, new events re-set after the clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & {N_PINS{~rd_clr}}) | evt;
    end

    // Summary bit: set by enabled flag-setting events, cleared by the read
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= 1'b0;
        else        sum_q <= (sum_q & ~rd_clr) | (|(evt & en_q));
    end

    // Enable field and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (wr_en_sel)   en_q   <= wr_data[N_PINS-1:0];
            if (wr_mask_sel) mask_q <= wr_data;
        end
    end

    assign stat  = {sum_q, other_src};
    assign irq_n = ~|(stat & mask_q);

    a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0 && !rd_clr) |=> ((flags & $past(flags)) == $past(flags)));
    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (flags == '0 && !stat[STAT_W-1]));
    a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
    a_r4_disabled_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[STAT_W-1] && (evt & en_q) == '0) |=> !stat[STAT_W-1]);
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !stat[STAT_W-1]));
endmodule

// File: rtl/pin_change_irq.sv
// Top: input change interrupt controller. One filter per pin, a shared
// sample tick and the status/mask logic.
// Assumes: all CPU strobes are synchronous to clk and one cycle wide.
module pin_change_irq
    import pcx_pkg::*;
#(
    parameter int N_PINS     = PCX_DEF_PINS,
    parameter int STAT_W     = PCX_DEF_STAT_W,
    parameter int SAMPLE_DIV = PCX_DEF_DIV
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PINS-1:0]   pin_in,
    input  logic [STAT_W-2:0]   other_src,
    input  logic [STAT_W-1:0]   wr_data,
    input  logic                wr_en_sel,
    input  logic                wr_mask_sel,
    input  logic                rd_chg,
    output logic [2*N_PINS-1:0] chg_data,
    output logic [STAT_W-1:0]   stat_data,
    output logic                irq_n
);
    logic              tick;
    logic [N_PINS-1:0] lvl;
    logic [N_PINS-1:0] evt;
    logic [N_PINS-1:0] flags;

    pcx_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pcx_pin_filter u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .pin  (pin_in[i]),
            .level(lvl[i]),
            .evt  (evt[i])
        );
    end

    pcx_status #(.N_PINS(N_PINS), .STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .other_src  (other_src),
        .wr_data    (wr_data),
        .wr_en_sel  (wr_en_sel),
        .wr_mask_sel(wr_mask_sel),
        .rd_clr     (rd_chg),
        .flags      (flags),
        .stat       (stat_data),
        .irq_n      (irq_n)
    );

    assign chg_data = {flags, lvl};
endmodule

// File: tb/pin_change_irq_test.sv
`timescale 1ns/100ps
module pin_change_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = 4'b0100;
    logic [6:0] other_src = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en_sel = 1'b0, wr_mask_sel = 1'b0, rd_chg = 1'b0;
    logic [7:0] chg_data, stat_data;
    logic       irq_n;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int         sel;   // 0 chg_data, 1 stat_data, 2 irq_n
        logic [7:0] msk;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    pin_change_irq uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .other_src(other_src),
        .wr_data(wr_data), .wr_en_sel(wr_en_sel), .wr_mask_sel(wr_mask_sel),
        .rd_chg(rd_chg), .chg_data(chg_data), .stat_data(stat_data), .irq_n(irq_n)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            act = (it.sel == 0) ? chg_data : (it.sel == 1) ? stat_data : {7'b0, irq_n};
            checks++;
            if ((act & it.msk) != (it.exp & it.msk)) begin
                failures++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act & it.msk, it.exp & it.msk);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_item(int sel, logic [7:0] msk, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.msk = msk; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        step(1);
    endtask

    task automatic direct(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_en(logic [3:0] v);
        wr_data = {4'b0, v}; wr_en_sel = 1'b1; step(1); wr_en_sel = 1'b0;
    endtask

    task automatic wr_mask(logic [7:0] v);
        wr_data = v; wr_mask_sel = 1'b1; step(1); wr_mask_sel = 1'b0;
    endtask

    task automatic rd_clear();
        rd_chg = 1'b1; step(1); rd_chg = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        int seen_flag, seen_sum;
        step(5);
        rst_n = 1'b1;
        step(20);
        // R7 / R10: reset state, pin 2 high through reset raises no flag
        expect_item(0, 8'hFF, 8'h04, "R10 primed, no flag");
        expect_item(1, 8'hFF, 8'h00, "R7 status reset");
        expect_item(2, 8'h01, 8'h01, "R7 irq_n idle");
        // R3: live level follows the pin
        pin_in = 4'b0101;
        step(3);
        expect_item(0, 8'h0F, 8'h05, "R3 live level");
        step(20);
        expect_item(0, 8'hFF, 8'h15, "R1 flag pin0");
        expect_item(1, 8'hFF, 8'h00, "R4 disabled no summary");
        wr_en(4'b0001);
        step(2);
        expect_item(1, 8'hFF, 8'h00, "R4 enable after flag");
        rd_clear();
        expect_item(0, 8'hFF, 8'h05, "R2 flags cleared");
        pin_in = 4'b0100;
        step(20);
        expect_item(0, 8'hFF, 8'h14, "R1 flag pin0 falling");
        expect_item(1, 8'hFF, 8'h80, "R4 enabled summary");
        expect_item(2, 8'h01, 8'h01, "R5 masked off");
        wr_mask(8'h80);
        expect_item(2, 8'h01, 8'h00, "R5 irq asserted");
        wr_mask(8'h00);
        expect_item(1, 8'hFF, 8'h80, "R6 status unmasked");
        other_src = 7'h05;
        wr_mask(8'h01);
        expect_item(1, 8'hFF, 8'h85, "R6 other sources");
        expect_item(2, 8'h01, 8'h00, "R5 other source irq");
        wr_mask(8'h02);
        expect_item(2, 8'h01, 8'h01, "R5 no overlap");
        rd_clear();
        expect_item(1, 8'hFF, 8'h05, "R2 summary cleared");
        expect_item(0, 8'hFF, 8'h04, "R2 change reg cleared");
        other_src = 7'h00;
        // R4: change on a disabled pin
        pin_in = 4'b1100;
        step(20);
        expect_item(0, 8'hFF, 8'h8C, "R1 flag pin3");
        expect_item(1, 8'hFF, 8'h00, "R4 pin3 disabled");
        rd_clear();
        // R8: two-cycle glitch on pin 1
        pin_in = 4'b1110;
        step(2);
        pin_in = 4'b1100;
        step(20);
        expect_item(0, 8'hFF, 8'h0C, "R8 glitch rejected");
        // R9: change while the clearing read is held every cycle
        wr_en(4'b0010);
        rd_chg = 1'b1;
        pin_in = 4'b1110;
        seen_flag = 0; seen_sum = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (chg_data[5]) seen_flag++;
            if (stat_data[7]) seen_sum++;
        end
        #1;
        rd_chg = 1'b0;
        direct(seen_flag == 1, "R9 flag survives clear", seen_flag, 1);
        direct(seen_sum == 1, "R9 summary survives clear", seen_sum, 1);
        step(1);
        expect_item(0, 8'hFF, 8'h0E, "R2 cleared after held read");
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule